// File: doc/BRIEF.md
# Per-Channel Command Recovery Timer

Some drives need a minimum quiet time between two command-register accesses. This block gives each of several drive channels its own countdown. A one-cycle access pulse on a channel loads that channel's programmed period into its counter. While the counter is non-zero, the channel's busy flag is high. Software polls the flag and waits for it to drop before it issues the next command.

A new access that arrives while the counter is running reloads the full period, so the timer can be retriggered. Each channel can be switched off, and then its flag is held at 0. A channel whose period is zero never raises its flag. The period is taken from the input at the moment of the access. At a 16 MHz clock, a period of about 1600 cycles gives the 100 µs that slow drives need. All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `cmd_recovery_timer`

## Requirements
- R1: There are NCH channels (default 4), each with its own timer. An access on one channel never changes the flag of another channel.
- R2: An access pulse sampled at a clock edge, on an enabled channel whose period P is non-zero, makes that channel's busy flag 1 from that edge onward.
- R3: Without further accesses, the flag stays 1 for exactly P cycles after the loading edge and then returns to 0.
- R4: An access while the timer runs reloads the full current period, so the flag stays 1 for P cycles after the latest access.
- R5: While a channel's enable is 0, its flag reads 0 and its accesses are ignored. Clearing enable during a run drops the flag at the next clock edge.
- R6: A channel with period 0 never raises its flag, even when it is accessed.
- R7: An active-low reset clears every timer, so all flags read 0 after reset.
- R8: The period is sampled only at the access. Changing the period input during a run does not change the length of that run.
- R9: The period field of channel c is bits [c*CNT_W +: CNT_W] of the flat period port, with CNT_W = 12 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_access | input | NCH | One-cycle pulse per channel on a command-register read or write |
| chan_en | input | NCH | Per-channel enable for the recovery timer |
| period_flat | input | NCH*CNT_W | Per-channel period in clock cycles, channel c at [c*CNT_W +: CNT_W] |
| settle_busy | output | NCH | Per-channel flag, 1 while the recovery time runs |

## Verification
The flag is driven straight from the counter register, so it rises at the same clock edge that samples the access. The bench changes inputs on falling edges and samples half a cycle after each edge. An access pulse ends at the sample point just after its loading edge, and the flag must read 1 there. The bench then waits P−1 more falling edges, expects 1, and waits one more edge, expecting 0. A disable is checked at the first falling edge after the edge that samples it.

// File: rtl/rec_pkg.sv
package rec_pkg;
  parameter int REC_NCH   = 4;
  parameter int REC_CNT_W = 12;
endpackage

// File: rtl/rec_trigger.sv
module rec_trigger #(
  parameter int CNT_W = rec_pkg::REC_CNT_W
) (
  input  logic             access,
  input  logic             enable,
  input  logic [CNT_W-1:0] period,
  output logic             fire
);
  // a load is only meaningful on an enabled channel with a non-zero period
  assign fire = access && enable && (period != '0);
endmodule

// File: rtl/rec_chan_timer.sv
module rec_chan_timer #(
  parameter int CNT_W = rec_pkg::REC_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             enable,
  input  logic [CNT_W-1:0] period,
  output logic             busy
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!enable)    cnt <= '0;
    else if (fire)       cnt <= period;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R2/R4/R8: a load takes the period presented at the access
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (busy && cnt == $past(period)));

  // R3: steady countdown between accesses
  p_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !fire && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  // R5: disabled channel reads idle on the next cycle
  p_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy);

  // R6: an idle timer stays idle without a load
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !fire) |=> !busy);
endmodule

// File: rtl/cmd_recovery_timer.sv
module cmd_recovery_timer #(
  parameter int NCH   = rec_pkg::REC_NCH,
  parameter int CNT_W = rec_pkg::REC_CNT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       cmd_access,
  input  logic [NCH-1:0]       chan_en,
  input  logic [NCH*CNT_W-1:0] period_flat,
  output logic [NCH-1:0]       settle_busy
);
  localparam int PW = NCH * CNT_W;

  logic [NCH-1:0] fire;

  // R1/R9: one independent trigger and timer per channel
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic [CNT_W-1:0] per_c;
    assign per_c = period_flat[c*CNT_W +: CNT_W];

    rec_trigger #(.CNT_W(CNT_W)) i_trig (
      .access (cmd_access[c]),
      .enable (chan_en[c]),
      .period (per_c),
      .fire   (fire[c])
    );

    rec_chan_timer #(.CNT_W(CNT_W)) i_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (fire[c]),
      .enable (chan_en[c]),
      .period (per_c),
      .busy   (settle_busy[c])
    );
  end

  // R7: the cycle after reset every flag is clear
  p_reset_r7: assert property (@(posedge clk)
    !rst_n |=> (settle_busy == '0));

  initial begin
    if (PW != NCH * CNT_W) $error("period port width mismatch");
  end
endmodule

// File: tb/test_cmd_recovery_timer.sv
module test_cmd_recovery_timer;
  localparam int NCH = 4;
  localparam int CW  = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0] cmd_access;
  logic [NCH-1:0] chan_en;
  logic [NCH*CW-1:0] period_flat;
  logic [NCH-1:0] settle_busy;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cmd_recovery_timer #(.NCH(NCH), .CNT_W(CW)) i_cmd_recovery_timer (
    .clk(clk), .rst_n(rst_n), .cmd_access(cmd_access), .chan_en(chan_en),
    .period_flat(period_flat), .settle_busy(settle_busy)
  );

  task automatic check(input logic [NCH-1:0] act, input logic [NCH-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic set_period(input int ch, input int p);
    period_flat[ch*CW +: CW] = CW'(p);
  endtask

  // R9: channel c period at [c*CW +: CW]; pulse returns at the sample after the loading edge
  task automatic pulse(input logic [NCH-1:0] m);
    @(negedge clk) cmd_access = m;
    @(negedge clk) cmd_access = '0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    wait_n(2);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    chan_en = '1;
    for (int c = 0; c < NCH; c++) set_period(c, 7);
    pulse(4'b1111);
    check(settle_busy, 4'b1111, "R2 all started");
    do_reset();
    check(settle_busy, 4'b0000, "R7 cleared by reset");
  endtask

  task automatic t_single();
    set_period(0, 5);
    pulse(4'b0001);
    check(settle_busy, 4'b0001, "R2 busy after access, R1 others idle");
    wait_n(4);
    check(settle_busy, 4'b0001, "R3 still busy at P-1");
    wait_n(1);
    check(settle_busy, 4'b0000, "R3 expired after P");
  endtask

  task automatic t_parallel();
    set_period(1, 3);
    set_period(2, 6);
    pulse(4'b0110);
    wait_n(2);
    check(settle_busy, 4'b0110, "R1 both running");
    wait_n(1);
    check(settle_busy, 4'b0100, "R1 ch1 ended, ch2 independent");
    wait_n(3);
    check(settle_busy, 4'b0000, "R1 ch2 ended at its own period");
  endtask

  task automatic t_retrigger();
    set_period(3, 6);
    pulse(4'b1000);
    wait_n(3);
    pulse(4'b1000);
    wait_n(5);
    check(settle_busy, 4'b1000, "R4 reload kept busy past first run");
    wait_n(1);
    check(settle_busy, 4'b0000, "R4 ends P after last access");
  endtask

  task automatic t_disable();
    set_period(0, 8);
    chan_en[0] = 1'b0;
    pulse(4'b0001);
    check(settle_busy, 4'b0000, "R5 access ignored when disabled");
    chan_en[0] = 1'b1;
    pulse(4'b0001);
    wait_n(2);
    @(negedge clk) chan_en[0] = 1'b0;
    @(negedge clk);
    check(settle_busy, 4'b0000, "R5 disable drops flag next edge");
    chan_en[0] = 1'b1;
    wait_n(2);
    check(settle_busy, 4'b0000, "R5 re-enable does not resume");
  endtask

  task automatic t_zero();
    set_period(2, 0);
    pulse(4'b0100);
    check(settle_busy, 4'b0000, "R6 zero period no flag");
    wait_n(3);
    check(settle_busy, 4'b0000, "R6 still idle");
  endtask

  task automatic t_latch();
    set_period(1, 4);
    pulse(4'b0010);
    set_period(1, 20);
    wait_n(3);
    check(settle_busy, 4'b0010, "R8 running at P-1");
    wait_n(1);
    check(settle_busy, 4'b0000, "R8 old period kept");
  endtask

  task automatic t_long();
    set_period(0, 1600);
    pulse(4'b0001);
    wait_n(1599);
    check(settle_busy, 4'b0001, "R3 long period still busy");
    wait_n(1);
    check(settle_busy, 4'b0000, "R3 long period expired");
  endtask

  initial begin
    rst_n = 1'b0;
    cmd_access = '0;
    chan_en = '1;
    period_flat = '0;
    wait_n(3);
    check(settle_busy, 4'b0000, "R7 idle in reset");
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_parallel();
    t_retrigger();
    t_disable();
    t_zero();
    t_latch();
    t_long();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule